// File: doc/BRIEF.md
# SPI Command Sequencer

This block executes a stream of 16-bit commands that describe SPI bus activity. Each command arrives on a ready/valid input and is accepted only while the sequencer is idle. The sequencer decodes it into one of five operations. A transfer hands a word count and read/write enables to a separate serial shifter and waits for it to finish. A chip-select update drives a new select pattern, with a programmable settling delay before and after the change. A configuration write loads one of three 8-bit settings: the clock divider, the bus mode and the transfer bit length. A synchronize operation emits an 8-bit marker on a ready/valid output so that software can follow the progress of the stream. A sleep operation pauses execution for a programmed time.

All waits are counted in prescaled ticks. A tick counter runs from zero up to the divider value and restarts each time the sequencer changes state. The three configuration values feed the shifter directly. Commands whose reserved bits are set, or whose sub-code is not defined, are consumed and have no effect.

The controller has seven states. IDLE accepts commands. CS_PRE waits before the select update. CS_POST waits after it. XREQ pulses the shifter start. XWAIT waits for the shifter to report done. SYNC presents the marker. SLEEP pauses. The transitions are:
- IDLE→XREQ on a transfer, then XREQ→XWAIT unconditionally, and XWAIT→IDLE on done.
- IDLE→CS_PRE on a select command, CS_PRE→CS_POST when the wait ends, with the select updated on that edge, and CS_POST→IDLE when the second wait ends.
- IDLE→SYNC on a synchronize, and SYNC→IDLE when the consumer takes the marker.
- IDLE→SLEEP on a sleep, and SLEEP→IDLE when the wait ends.
- A configuration write or an ignored command leaves the controller in IDLE.

Top module: `spi_cmd_seq`

## Requirements
- R1: Reset state: `cs_n` is all ones; the divider and the mode are 0; the length is DATA_W; `cmd_ready` is 1; `sync_valid` and `xfer_start` are 0.
- R2: Field layout. Bits 13:12 select the class: 00 transfer, 01 chip-select, 10 configuration, 11 miscellaneous. Bits 9:8 form the sub-field, and bits 7:0 the argument. A command is legal only when bits 15, 14, 11 and 10 are all zero.
- R3: A transfer accepted on a clock edge raises `xfer_start` for exactly the next cycle. While it is high, `xfer_rd` equals bit 9, `xfer_wr` equals bit 8 and `xfer_words` equals bits 7:0 (the word count minus one).
- R4: After a transfer starts, `cmd_ready` stays low until `xfer_done` is sampled high. It returns high one cycle after that sample.
- R5: A chip-select command has its delay t in bits 9:8 and its pattern in bits 7:0. With divider d, `cs_n` takes the pattern t·(d+1)+1 clock edges after the accept edge. `cmd_ready` returns 2·(t·(d+1)+1) edges after the accept edge.
- R6: A configuration write takes effect on the edge after acceptance and leaves `cmd_ready` high. Sub-field 00 writes the divider, 01 writes the mode and 10 writes the length. Sub-field 11 changes nothing.
- R7: A synchronize command (class 11, sub-field 00) holds `sync_valid` high, with `sync_id` equal to bits 7:0, from the cycle after acceptance until `sync_ready` is sampled. No command is accepted meanwhile.
- R8: A sleep command (class 11, sub-field 01, time t in bits 7:0) returns `cmd_ready` high 2·(t+1)·(d+1)+1 edges after the accept edge.
- R9: An illegal command, or class 11 with sub-field 10 or 11, is accepted. `cmd_ready` stays high and no output changes.
- R10: `cmd_ready` is high only while idle. It is never high together with `xfer_start` or `sync_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and taking a command |
| cmd_data | input | 16 | Command word |
| sync_valid | output | 1 | Marker available |
| sync_ready | input | 1 | Consumer takes the marker |
| sync_id | output | 8 | Marker value |
| cs_n | output | 8 | Chip-select pattern, low selects |
| xfer_start | output | 1 | One-cycle start request to the shifter |
| xfer_rd | output | 1 | Shifter should capture input data |
| xfer_wr | output | 1 | Shifter should drive output data |
| xfer_words | output | 8 | Word count minus one |
| xfer_done | input | 1 | Shifter finished the transfer |
| cfg_div | output | 8 | Clock divider setting |
| cfg_mode | output | 8 | Bus mode setting |
| cfg_len | output | 8 | Transfer bit length |

## Verification
Most internal faults appear at the ports as a wrong number of cycles between a command's acceptance and the next rise of `cmd_ready`. A divider or tick fault changes the chip-select and sleep counts by at least one cycle, and this is caught on the first timed command. A faulty decode shows up on the cycle after acceptance, either as the wrong operation starting or as a change in a configuration output that should have stayed fixed. A broken handshake is exposed while the bench holds `xfer_done` or `sync_ready` low for a random number of cycles: either `cmd_ready` rises early or the marker changes.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int CMD_W = 16;
    localparam int CFG_W = 8;
    localparam int SEL_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CS_PRE,
        ST_CS_POST,
        ST_XREQ,
        ST_XWAIT,
        ST_SYNC,
        ST_SLEEP
    } seq_state_t;

    typedef enum logic [1:0] {
        CL_XFER = 2'b00,
        CL_CS   = 2'b01,
        CL_CFG  = 2'b10,
        CL_MISC = 2'b11
    } cmd_class_t;

    // reserved bits 15,14,11,10 must be clear
    function automatic logic cmd_legal(input logic [CMD_W-1:0] w);
        return (w[15:14] == 2'b00) && (w[11:10] == 2'b00);
    endfunction

endpackage

// File: rtl/seq_tick.sv
module seq_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)     pre_q <= '0;
        else if (pre_q == div) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
    end

    assign tick = (pre_q == div);

    // R8
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= div);
endmodule

// File: rtl/seq_cfg.sv
module seq_cfg #(
    parameter int CFG_W   = 8,
    parameter int LEN_RST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       sel,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] div,
    output logic [CFG_W-1:0] mode,
    output logic [CFG_W-1:0] len
);
    localparam logic [CFG_W-1:0] LEN_INIT = CFG_W'(LEN_RST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div  <= '0;
            mode <= '0;
            len  <= LEN_INIT;
        end else if (wr_en) begin
            unique case (sel)
                2'b00:   div  <= wdata;
                2'b01:   mode <= wdata;
                2'b10:   len  <= wdata;
                default: ;
            endcase
        end
    end

    // R6
    div_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div) |-> $past(wr_en && sel == 2'b00));
    // R6
    len_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(len) |-> $past(wr_en && sel == 2'b10));
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WAIT_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [15:0] cmd_data,
    output logic        sync_valid,
    input  logic        sync_ready,
    output logic [7:0]  sync_id,
    output logic [7:0]  cs_n,
    output logic        xfer_start,
    output logic        xfer_rd,
    output logic        xfer_wr,
    output logic [7:0]  xfer_words,
    input  logic        xfer_done,
    output logic [7:0]  cfg_div,
    output logic [7:0]  cfg_mode,
    output logic [7:0]  cfg_len
);
    seq_state_t        st_q, st_d;
    logic [9:0]        arg_q;
    logic [WAIT_W-1:0] wcnt_q, target;
    logic              wait_done, tick, tick_clr, accept, legal, cfg_we;
    cmd_class_t        cls;
    logic [1:0]        sub;

    assign cls    = cmd_class_t'(cmd_data[13:12]);
    assign sub    = cmd_data[9:8];
    assign legal  = cmd_legal(cmd_data);
    assign accept = cmd_valid && cmd_ready;
    assign cfg_we = accept && legal && (cls == CL_CFG);

    seq_cfg #(.CFG_W(CFG_W), .LEN_RST(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .sel(sub),
        .wdata(cmd_data[7:0]), .div(cfg_div), .mode(cfg_mode), .len(cfg_len)
    );

    assign tick_clr = (st_q != st_d) || (st_q == ST_IDLE);

    seq_tick #(.DIV_W(CFG_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(tick_clr), .div(cfg_div), .tick(tick)
    );

    always_comb begin
        unique case (st_q)
            ST_CS_PRE, ST_CS_POST: target = WAIT_W'(arg_q[9:8]);
            ST_SLEEP:              target = (WAIT_W'(arg_q[7:0]) + WAIT_W'(1)) << 1;
            default:               target = '0;
        endcase
    end
    assign wait_done = (wcnt_q == target);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_valid && legal) begin
                    if (cls == CL_XFER)                      st_d = ST_XREQ;
                    else if (cls == CL_CS)                   st_d = ST_CS_PRE;
                    else if (cls == CL_MISC && sub == 2'b00) st_d = ST_SYNC;
                    else if (cls == CL_MISC && sub == 2'b01) st_d = ST_SLEEP;
                end
            end
            ST_CS_PRE:  if (wait_done)  st_d = ST_CS_POST;
            ST_CS_POST: if (wait_done)  st_d = ST_IDLE;
            ST_SLEEP:   if (wait_done)  st_d = ST_IDLE;
            ST_XREQ:                    st_d = ST_XWAIT;
            ST_XWAIT:   if (xfer_done)  st_d = ST_IDLE;
            ST_SYNC:    if (sync_ready) st_d = ST_IDLE;
            default:                    st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready  = (st_q == ST_IDLE);
        xfer_start = (st_q == ST_XREQ);
        sync_valid = (st_q == ST_SYNC);
    end
    assign xfer_rd    = arg_q[9];
    assign xfer_wr    = arg_q[8];
    assign xfer_words = arg_q[7:0];
    assign sync_id    = arg_q[7:0];

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q  <= '0;
            cs_n   <= '1;
            wcnt_q <= '0;
        end else begin
            if (accept) arg_q <= cmd_data[9:0];
            if (st_q == ST_CS_PRE && wait_done) cs_n <= arg_q[7:0];
            if (st_q != st_d)              wcnt_q <= '0;
            else if (tick && !wait_done)   wcnt_q <= wcnt_q + 1'b1;
        end
    end

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !xfer_start && !sync_valid);
    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start && !cmd_ready);
    // R4
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XWAIT && !xfer_done) |=> !cmd_ready);
    // R7
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_valid && !sync_ready) |=> sync_valid && $stable(sync_id));
    // R5
    cs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_n) |-> $past(st_q) == ST_CS_PRE);
    // R9
    noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !legal) |=> cmd_ready && $stable(cs_n));
endmodule

// File: tb/spi_cmd_seq_test.sv
module spi_cmd_seq_test;
    localparam int CLK_NS = 10;

    logic        clk = 0, rst_n = 0;
    logic        cmd_valid = 0, sync_ready = 0, xfer_done = 0;
    logic [15:0] cmd_data = '0;
    logic        cmd_ready, sync_valid, xfer_start, xfer_rd, xfer_wr;
    logic [7:0]  sync_id, cs_n, xfer_words, cfg_div, cfg_mode, cfg_len;

    int total = 0, bad = 0;
    int m_div = 0, m_mode = 0, m_len = 8, m_cs = 255;

    spi_cmd_seq #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .sync_valid(sync_valid), .sync_ready(sync_ready),
        .sync_id(sync_id), .cs_n(cs_n), .xfer_start(xfer_start), .xfer_rd(xfer_rd),
        .xfer_wr(xfer_wr), .xfer_words(xfer_words), .xfer_done(xfer_done),
        .cfg_div(cfg_div), .cfg_mode(cfg_mode), .cfg_len(cfg_len)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cs_edges(input int t, input int d);
        return t * (d + 1) + 1;
    endfunction

    function automatic int sleep_edges(input int t, input int d);
        return 2 * (t + 1) * (d + 1) + 1;
    endfunction

    // returns at the falling edge after the accepting edge
    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1;
        cmd_data  = w;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic do_cfg(input int sel, input int v);
        send({4'b0010, 2'b00, 2'(sel), 8'(v)});
        if (sel == 0) m_div = v;
        else if (sel == 1) m_mode = v;
        else if (sel == 2) m_len = v;
        check("R6 div", cfg_div, m_div);
        check("R6 mode", cfg_mode, m_mode);
        check("R6 len", cfg_len, m_len);
        check("R6 ready", cmd_ready, 1);
    endtask

    task automatic do_cs(input int t, input int v);
        int n = 0, ncs = -1;
        send({4'b0001, 2'b00, 2'(t), 8'(v)});
        while (!cmd_ready) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (ncs < 0 && int'(cs_n) == v) ncs = n;
        end
        if (v != m_cs) check("R5 cs edges", ncs, cs_edges(t, m_div));
        m_cs = v;
        check("R5 cs value", cs_n, v);
        check("R5 ready edges", n, 2 * cs_edges(t, m_div));
    endtask

    task automatic do_sleep(input int t);
        int n = 0;
        send({4'b0011, 2'b00, 2'b01, 8'(t)});
        while (!cmd_ready) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        check("R8 sleep edges", n, sleep_edges(t, m_div));
    endtask

    task automatic do_xfer(input int rd, input int wr, input int words, input int k);
        int err = 0;
        send({4'b0000, 2'b00, 1'(rd), 1'(wr), 8'(words)});
        check("R3 start", xfer_start, 1);
        check("R3 fields", {xfer_rd, xfer_wr, xfer_words}, {1'(rd), 1'(wr), 8'(words)});
        for (int i = 0; i <= k; i++) begin
            @(negedge clk);
            if (xfer_start || cmd_ready) err++;
        end
        check("R4 blocked while busy", err, 0);
        xfer_done = 1;
        @(negedge clk);
        xfer_done = 0;
        check("R4 ready after done", cmd_ready, 1);
    endtask

    task automatic do_sync(input int id, input int k);
        int err = 0;
        send({4'b0011, 2'b00, 2'b00, 8'(id)});
        check("R7 valid", sync_valid, 1);
        check("R7 id", sync_id, id);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (!sync_valid || int'(sync_id) != id || cmd_ready) err++;
        end
        check("R7 hold", err, 0);
        sync_ready = 1;
        @(negedge clk);
        sync_ready = 0;
        check("R7 released", {sync_valid, cmd_ready}, 2'b01);
    endtask

    task automatic do_noop(input logic [15:0] w);
        send(w);
        check("R9 ready", cmd_ready, 1);
        check("R9 cs", cs_n, m_cs);
        check("R9 cfg", {cfg_div, cfg_mode, cfg_len}, {8'(m_div), 8'(m_mode), 8'(m_len)});
        check("R9 quiet", {xfer_start, sync_valid}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check("R1 cs", cs_n, 255);
        check("R1 cfg", {cfg_div, cfg_mode, cfg_len}, {8'd0, 8'd0, 8'd8});
        check("R1 handshakes", {cmd_ready, sync_valid, xfer_start}, 3'b100);

        // directed corners
        do_cs(0, 8'hA5);
        do_sleep(0);
        do_cfg(1, 8'h03);
        do_noop({4'b0010, 2'b00, 2'b11, 8'h55}); // R6 sub-field 11
        do_noop(16'h8000 | 16'h1000 | 16'h0012); // R9 reserved bit set
        do_noop({4'b0011, 2'b00, 2'b10, 8'h44}); // R9 R2 undefined sub-field
        do_xfer(1, 0, 0, 0);
        do_sync(8'h7E, 0);
        do_cfg(0, 255);
        do_cs(3, 8'h3C);
        do_sleep(1);
        do_cfg(0, 0);
        do_cfg(2, 16);

        for (int it = 0; it < 60; it++) begin
            int op = $urandom % 6;
            case (op)
                0: do_cfg($urandom % 3, (op == 0) ? $urandom % 8 : 0);
                1: do_cs($urandom % 4, $urandom % 256);
                2: do_sleep($urandom % 32);
                3: do_xfer($urandom % 2, $urandom % 2, $urandom % 256, $urandom % 6);
                4: do_sync($urandom % 256, $urandom % 6);
                default: do_noop(16'h0400 | 16'($urandom % 65536));
            endcase
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule